// File: doc/BRIEF.md
# MOESI Snooping Line Controller with Shared Handshake

This block keeps the coherence state of a small direct-mapped, write-back cache on a snooping bus. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. A one-word block is tracked per line. Processor reads and writes arrive on a simple request/done handshake. Misses, upgrades and victim write-backs leave as single-cycle bus requests that an external arbiter grants. Transactions from other caches arrive as snoops, one per cycle.

Requests from other caches are answered in the same cycle with four signals. The shared handshake is driven for every read request that finds a valid copy. Flush means this cache supplies the block. Inhibit tells memory not to drive data. Write-back tells memory to capture the flushed block. A dirty line that another cache reads becomes Owned. It keeps supplying the block to later readers, and memory is only updated when ownership ends.

The bus is serial, so a grant and a snoop never share a cycle. A snoop always wins over a processor request presented in the same cycle.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_done` and `bus_req_valid` are low, and a snooped read raises none of the snoop responses.
- R2: A read miss issues a read request (`bus_req_cmd` 1) for `cpu_addr`. The granted fill data is returned on `cpu_rdata`. The line fills Exclusive if `bus_shared_in` was low in the grant cycle, and Shared if it was high. A read hit completes with no bus request.
- R3: A snooped read (`snp_cmd` 1) that hits any valid copy raises `snp_shared` in that cycle, and an Exclusive line drops to Shared.
- R4: A processor write to an Exclusive or Modified line completes with no bus request, and the line becomes Modified. `cpu_done` is a single-cycle pulse.
- R5: A snooped read hitting a Modified line raises `snp_flush` and `snp_inhibit` with the line data on `snp_data`, and the line becomes Owned with no write-back. An Owned line answers each later snooped read the same way.
- R6: A processor write to a Shared or Owned line issues an upgrade (`bus_req_cmd` 3) and the line becomes Modified.
- R7: A snooped read-exclusive (`snp_cmd` 2) hitting a Modified, Owned or Exclusive line raises `snp_flush` and invalidates the line. Any hit invalidates the line.
- R8: A snooped upgrade (`snp_cmd` 3) invalidates Shared and Owned lines. An Owned line raises `snp_wb` with its data. A Modified or Owned line invalidated by a read-exclusive also raises `snp_wb`.
- R9: A miss whose victim is Modified or Owned first issues a write-back (`bus_req_cmd` 0) carrying the victim's address and data, then the fill request. A clean victim is dropped with no bus request. The line index is `addr % LINES`.
- R10: A write miss issues a read-exclusive (`bus_req_cmd` 2), and the line becomes Modified holding the write data.
- R11: A processor request is not taken in a cycle that carries a snoop. A pending upgrade whose line a snoop invalidated turns into a read-exclusive.
- R12: `snp_inhibit` is raised only for a hit on a Modified or Owned line by a read or read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 write-back, 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_addr | output | ADDR_W | Address of the requested transaction |
| bus_req_data | output | DATA_W | Data for a write-back |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired shared line, sampled with the grant |
| bus_fill_data | input | DATA_W | Fill data, sampled with the grant |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Foreign command, same coding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Foreign address |
| snp_shared | output | 1 | Drive of the shared line |
| snp_flush | output | 1 | This cache supplies the block |
| snp_inhibit | output | 1 | Memory must not drive data |
| snp_wb | output | 1 | Memory must capture the flushed block |
| snp_data | output | DATA_W | Block supplied by this cache |

## Verification
Several rules are checked on every cycle. The shared handshake appears only on foreign reads. Memory is inhibited only when this cache flushes. A write-back is never caused by a plain read. An Owned line keeps supplying back-to-back readers, and completion is a single pulse. Other behaviours only show in the bench's ordered scenarios. These are the Exclusive or Shared choice on fill, silent versus upgrading writes, victim write-back ordering, and an upgrade that a snoop overtakes. They also include the snoop-over-processor precedence, where the state seen later differs by one bus command.

// File: rtl/moesi_snoop_ctrl.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic              snp_inhibit,
  output logic              snp_wb,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] CMD_WB = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3;

  typedef enum logic [2:0] {LS_I, LS_S, LS_E, LS_O, LS_M} lstate_t;
  typedef enum logic [2:0] {F_IDLE, F_EVICT, F_FETCH, F_UPG, F_DONE} fsm_t;

  lstate_t           st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  fsm_t              fsm_q, fsm_d;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  lstate_t          c_st, s_st, s_next;
  logic             c_match, c_dirty, c_upg_ok, s_hit, s_dirty;

  assign c_idx    = cpu_addr[IDX_W-1:0];
  assign c_tag    = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx    = snp_addr[IDX_W-1:0];
  assign s_tag    = snp_addr[ADDR_W-1:IDX_W];
  assign c_st     = st_q[c_idx];
  assign s_st     = st_q[s_idx];
  assign c_match  = (c_st != LS_I) && (tag_q[c_idx] == c_tag);
  assign c_dirty  = (c_st == LS_M) || (c_st == LS_O);
  assign c_upg_ok = c_match && ((c_st == LS_S) || (c_st == LS_O));
  assign s_hit    = snp_valid && (s_st != LS_I) && (tag_q[s_idx] == s_tag);
  assign s_dirty  = (s_st == LS_M) || (s_st == LS_O);

  assign snp_shared  = s_hit && (snp_cmd == CMD_RD);
  assign snp_flush   = s_hit && (((snp_cmd == CMD_RD) && s_dirty) ||
                                 ((snp_cmd == CMD_RDX) && (s_dirty || s_st == LS_E)));
  assign snp_inhibit = s_hit && s_dirty && ((snp_cmd == CMD_RD) || (snp_cmd == CMD_RDX));
  assign snp_wb      = s_hit && (((snp_cmd == CMD_RDX) && s_dirty) ||
                                 ((snp_cmd == CMD_UPG) && (s_st == LS_O)));
  assign snp_data    = dat_q[s_idx];

  always_comb begin
    s_next = s_st;
    case (snp_cmd)
      CMD_RD:  if (s_st == LS_M) s_next = LS_O;
               else if (s_st == LS_E) s_next = LS_S;
      CMD_RDX: s_next = LS_I;
      CMD_UPG: if ((s_st == LS_S) || (s_st == LS_O)) s_next = LS_I;
      default: s_next = s_st;
    endcase
  end

  assign cpu_done      = (fsm_q == F_DONE);
  assign bus_req_valid = ((fsm_q == F_EVICT) && c_dirty) || (fsm_q == F_FETCH) ||
                         ((fsm_q == F_UPG) && c_upg_ok);
  assign bus_req_cmd   = (fsm_q == F_EVICT) ? CMD_WB :
                         (fsm_q == F_UPG)   ? CMD_UPG :
                         (cpu_we ? CMD_RDX : CMD_RD);
  assign bus_req_addr  = (fsm_q == F_EVICT) ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_req_data  = dat_q[c_idx];

  logic              upd_st, upd_tag, upd_dat, rd_ld;
  lstate_t           new_st;
  logic [DATA_W-1:0] new_dat, rd_d;

  always_comb begin
    fsm_d   = fsm_q;
    upd_st  = 1'b0;
    upd_tag = 1'b0;
    upd_dat = 1'b0;
    rd_ld   = 1'b0;
    new_st  = c_st;
    new_dat = cpu_wdata;
    rd_d    = dat_q[c_idx];
    case (fsm_q)
      F_IDLE: if (cpu_req && !snp_valid) begin
        if (c_match) begin
          if (!cpu_we) begin
            rd_ld = 1'b1;
            fsm_d = F_DONE;
          end else if ((c_st == LS_M) || (c_st == LS_E)) begin
            upd_st  = 1'b1;
            new_st  = LS_M;
            upd_dat = 1'b1;
            fsm_d   = F_DONE;
          end else begin
            fsm_d = F_UPG;
          end
        end else begin
          fsm_d = c_dirty ? F_EVICT : F_FETCH;
        end
      end
      F_EVICT: if (!c_dirty) begin
        fsm_d = F_FETCH;
      end else if (bus_gnt) begin
        upd_st = 1'b1;
        new_st = LS_I;
        fsm_d  = F_FETCH;
      end
      F_FETCH: if (bus_gnt) begin
        upd_st  = 1'b1;
        upd_tag = 1'b1;
        upd_dat = 1'b1;
        fsm_d   = F_DONE;
        if (cpu_we) begin
          new_st = LS_M;
        end else begin
          new_st  = bus_shared_in ? LS_S : LS_E;
          new_dat = bus_fill_data;
          rd_ld   = 1'b1;
          rd_d    = bus_fill_data;
        end
      end
      F_UPG: if (!c_upg_ok) begin
        fsm_d = F_FETCH;
      end else if (bus_gnt) begin
        upd_st  = 1'b1;
        new_st  = LS_M;
        upd_dat = 1'b1;
        fsm_d   = F_DONE;
      end
      F_DONE: fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      cpu_rdata <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (rd_ld) cpu_rdata <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (s_hit) begin
      st_q[s_idx] <= s_next;
    end else begin
      if (upd_st)  st_q[c_idx]  <= new_st;
      if (upd_tag) tag_q[c_idx] <= c_tag;
      if (upd_dat) dat_q[c_idx] <= new_dat;
    end
  end
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared,
  input logic              snp_flush,
  input logic              snp_inhibit,
  input logic              snp_wb,
  input logic              cpu_done
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_shared_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_cmd == 2'd1));

  p_inhibit_needs_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> snp_flush);

  p_wb_not_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> (snp_valid && snp_cmd != 2'd1));

  p_flush_needs_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid);

  p_owner_keeps_serving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && snp_valid && snp_cmd == 2'd1 && snp_addr == $past(snp_addr) &&
     $past(snp_valid && snp_cmd == 2'd1 && snp_flush)) |-> snp_flush);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush),
  .snp_inhibit(snp_inhibit), .snp_wb(snp_wb), .cpu_done(cpu_done)
);

// File: tb/moesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4, ADDR_W = 8, DATA_W = 16;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata, bus_req_data, bus_fill_data = '0, snp_data;
  logic cpu_done, bus_req_valid, bus_gnt = 0, bus_shared_in = 0;
  logic [1:0] bus_req_cmd, snp_cmd = 2'd0;
  logic [ADDR_W-1:0] bus_req_addr, snp_addr = '0;
  logic snp_valid = 0, snp_shared, snp_flush, snp_inhibit, snp_wb;

  int nchecks = 0, nfails = 0;
  int wb_addr = -1, wb_data = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_data(bus_req_data), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .bus_fill_data(bus_fill_data), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush),
    .snp_inhibit(snp_inhibit), .snp_wb(snp_wb), .snp_data(snp_data));

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", r, what, act, exp, $time);
    end
  endtask

  // Reference model: states 0=I 1=S 2=E 3=O 4=M; phases 0 idle 1 evict 2 fetch 3 upgrade 4 done
  int m_st[LINES], m_tag[LINES], m_dat[LINES];
  int m_ph = 0, m_rd = 0;

  initial for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
      m_ph = 0; m_rd = 0;
    end else begin
      int ci, ct, si, stg, np;
      bit hit_s, cm, cd, up;
      ci = int'(cpu_addr) % LINES; ct = int'(cpu_addr) / LINES;
      si = int'(snp_addr) % LINES; stg = int'(snp_addr) / LINES;
      hit_s = snp_valid && m_st[si] != 0 && m_tag[si] == stg;
      cm = m_st[ci] != 0 && m_tag[ci] == ct;
      cd = m_st[ci] >= 3;
      up = cm && (m_st[ci] == 1 || m_st[ci] == 3);
      np = m_ph;
      if (hit_s) begin
        if (snp_cmd == 1) begin
          if (m_st[si] == 4) m_st[si] = 3; else if (m_st[si] == 2) m_st[si] = 1;
        end else if (snp_cmd == 2) m_st[si] = 0;
        else if (snp_cmd == 3 && (m_st[si] == 1 || m_st[si] == 3)) m_st[si] = 0;
      end
      if (m_ph == 0) begin
        if (cpu_req && !snp_valid) begin
          if (cm) begin
            if (!cpu_we) begin m_rd = m_dat[ci]; np = 4; end
            else if (m_st[ci] == 4 || m_st[ci] == 2) begin m_st[ci] = 4; m_dat[ci] = int'(cpu_wdata); np = 4; end
            else np = 3;
          end else np = cd ? 1 : 2;
        end
      end else if (m_ph == 1) begin
        if (!cd) np = 2; else if (bus_gnt) begin m_st[ci] = 0; np = 2; end
      end else if (m_ph == 2) begin
        if (bus_gnt) begin
          m_tag[ci] = ct; np = 4;
          if (cpu_we) begin m_st[ci] = 4; m_dat[ci] = int'(cpu_wdata); end
          else begin m_st[ci] = bus_shared_in ? 1 : 2; m_dat[ci] = int'(bus_fill_data); m_rd = int'(bus_fill_data); end
        end
      end else if (m_ph == 3) begin
        if (!up) np = 2; else if (bus_gnt) begin m_st[ci] = 4; m_dat[ci] = int'(cpu_wdata); np = 4; end
      end else np = 0;
      m_ph = np;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      int ci, ct, si, stg, ev, ec, ea, s;
      bit hit_s, cm, dirty_s;
      ci = int'(cpu_addr) % LINES; ct = int'(cpu_addr) / LINES;
      si = int'(snp_addr) % LINES; stg = int'(snp_addr) / LINES;
      cm = m_st[ci] != 0 && m_tag[ci] == ct;
      s = m_st[si];
      hit_s = snp_valid && s != 0 && m_tag[si] == stg;
      dirty_s = s >= 3;
      ev = (m_ph == 1 && m_st[ci] >= 3) || m_ph == 2 ||
           (m_ph == 3 && cm && (m_st[ci] == 1 || m_st[ci] == 3));
      ec = (m_ph == 1) ? 0 : (m_ph == 3) ? 3 : (cpu_we ? 2 : 1);
      ea = (m_ph == 1) ? m_tag[ci] * LINES + ci : int'(cpu_addr);
      chk(cpu_done == (m_ph == 4), "R4", "cpu_done", int'(cpu_done), int'(m_ph == 4));
      chk(bus_req_valid == ev, "R9", "bus_req_valid", int'(bus_req_valid), ev);
      if (bus_req_valid && ev) begin
        chk(int'(bus_req_cmd) == ec, "R2", "bus_req_cmd", int'(bus_req_cmd), ec);
        chk(int'(bus_req_addr) == ea, "R9", "bus_req_addr", int'(bus_req_addr), ea);
        if (ec == 0) chk(int'(bus_req_data) == m_dat[ci], "R9", "bus_req_data", int'(bus_req_data), m_dat[ci]);
      end
      chk(snp_shared == (hit_s && snp_cmd == 1), "R3", "snp_shared", int'(snp_shared), int'(hit_s && snp_cmd == 1));
      chk(snp_flush == (hit_s && ((snp_cmd == 1 && dirty_s) || (snp_cmd == 2 && s >= 2))), "R7", "snp_flush",
          int'(snp_flush), int'(hit_s && ((snp_cmd == 1 && dirty_s) || (snp_cmd == 2 && s >= 2))));
      chk(snp_inhibit == (hit_s && dirty_s && (snp_cmd == 1 || snp_cmd == 2)), "R12", "snp_inhibit",
          int'(snp_inhibit), int'(hit_s && dirty_s && (snp_cmd == 1 || snp_cmd == 2)));
      chk(snp_wb == (hit_s && ((snp_cmd == 2 && dirty_s) || (snp_cmd == 3 && s == 3))), "R8", "snp_wb",
          int'(snp_wb), int'(hit_s && ((snp_cmd == 2 && dirty_s) || (snp_cmd == 3 && s == 3))));
      if (snp_flush || snp_wb) chk(int'(snp_data) == m_dat[si], "R5", "snp_data", int'(snp_data), m_dat[si]);
      if (cpu_done && !cpu_we) chk(int'(cpu_rdata) == m_rd, "R2", "cpu_rdata", int'(cpu_rdata), m_rd);
    end
  end

  task automatic snoop(input int cmd, input int addr, input int e_sh, input int e_fl,
                       input int e_inh, input int e_wb, input int e_dat, input string r);
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = ADDR_W'(addr);
    #(CLK_PERIOD/4);
    chk(int'(snp_shared) == e_sh, r, "snoop shared", int'(snp_shared), e_sh);
    chk(int'(snp_flush) == e_fl, r, "snoop flush", int'(snp_flush), e_fl);
    chk(int'(snp_inhibit) == e_inh, r, "snoop inhibit", int'(snp_inhibit), e_inh);
    chk(int'(snp_wb) == e_wb, r, "snoop write-back", int'(snp_wb), e_wb);
    if (e_dat >= 0) chk(int'(snp_data) == e_dat, r, "snoop data", int'(snp_data), e_dat);
    @(negedge clk);
    snp_valid = 0;
  endtask

  // Granted command sequence is encoded as digits (cmd+1), first command most significant
  task automatic cpu_op(input bit we, input int addr, input int wdata, input bit sh, input int fill,
                        input int snp_start, input int snp_at_req, input int exp_seq,
                        input int exp_rd, input string r);
    int seq = 0, rd = 0, pend = snp_at_req;
    bit got = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DATA_W'(wdata);
    if (snp_start >= 0) begin snp_valid = 1; snp_cmd = 2'(snp_start); snp_addr = ADDR_W'(addr); end
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      snp_valid = 0; bus_gnt = 0;
      if (cpu_done) begin
        got = 1; rd = int'(cpu_rdata); cpu_req = 0;
      end else if (bus_req_valid) begin
        if (pend >= 0) begin
          snp_valid = 1; snp_cmd = 2'(pend); snp_addr = ADDR_W'(addr); pend = -1;
        end else begin
          seq = seq * 10 + int'(bus_req_cmd) + 1;
          if (bus_req_cmd == 2'd0) begin wb_addr = int'(bus_req_addr); wb_data = int'(bus_req_data); end
          bus_gnt = 1; bus_shared_in = sh; bus_fill_data = DATA_W'(fill);
        end
      end
    end
    cpu_req = 0;
    chk(got, r, "operation completed", int'(got), 1);
    chk(seq == exp_seq, r, "bus command sequence", seq, exp_seq);
    if (exp_rd >= 0) chk(rd == exp_rd, r, "read data", rd, exp_rd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #(CLK_PERIOD/4);
    chk(!cpu_done && !bus_req_valid, "R1", "idle after reset", int'({cpu_done, bus_req_valid}), 0);
    snoop(1, 'h10, 0, 0, 0, 0, -1, "R1");

    cpu_op(0, 'h04, 0, 0, 'hAAAA, -1, -1, 2, 'hAAAA, "R2");
    cpu_op(1, 'h04, 'h1111, 0, 0, -1, -1, 0, -1, "R4");
    snoop(1, 'h04, 1, 1, 1, 0, 'h1111, "R5");
    snoop(1, 'h04, 1, 1, 1, 0, 'h1111, "R5");
    cpu_op(0, 'h04, 0, 0, 0, -1, -1, 0, 'h1111, "R2");
    cpu_op(1, 'h04, 'h2222, 0, 0, -1, -1, 4, -1, "R6");
    snoop(2, 'h04, 0, 1, 1, 1, 'h2222, "R7");
    snoop(1, 'h04, 0, 0, 0, 0, -1, "R7");

    cpu_op(0, 'h05, 0, 1, 'h3333, -1, -1, 2, 'h3333, "R2");
    snoop(1, 'h05, 1, 0, 0, 0, -1, "R12");
    cpu_op(1, 'h05, 'h4444, 0, 0, -1, -1, 4, -1, "R6");

    cpu_op(1, 'h06, 'h5555, 0, 'hFFFF, -1, -1, 3, -1, "R10");
    snoop(1, 'h06, 1, 1, 1, 0, 'h5555, "R10");
    snoop(3, 'h06, 0, 0, 0, 1, 'h5555, "R8");
    snoop(1, 'h06, 0, 0, 0, 0, -1, "R8");

    cpu_op(0, 'h07, 0, 1, 'h6666, -1, -1, 2, 'h6666, "R2");
    snoop(3, 'h07, 0, 0, 0, 0, -1, "R8");
    snoop(1, 'h07, 0, 0, 0, 0, -1, "R8");

    cpu_op(0, 'h09, 0, 0, 'h7777, -1, -1, 12, 'h7777, "R9");
    chk(wb_addr == 'h05, "R9", "victim address", wb_addr, 'h05);
    chk(wb_data == 'h4444, "R9", "victim data", wb_data, 'h4444);
    cpu_op(0, 'h0D, 0, 0, 'h8888, -1, -1, 2, 'h8888, "R9");

    snoop(1, 'h0D, 1, 0, 0, 0, -1, "R3");
    cpu_op(1, 'h0D, 'h9999, 0, 0, -1, -1, 4, -1, "R3");

    cpu_op(0, 'h0A, 0, 0, 'hABCD, -1, -1, 2, 'hABCD, "R2");
    snoop(2, 'h0A, 0, 1, 0, 0, 'hABCD, "R7");

    cpu_op(0, 'h0B, 0, 1, 'h1234, -1, -1, 2, 'h1234, "R2");
    cpu_op(1, 'h0B, 'h5678, 0, 'hFFFF, -1, 3, 3, -1, "R11");
    snoop(1, 'h0B, 1, 1, 1, 0, 'h5678, "R11");

    cpu_op(0, 'h0E, 0, 0, 'h0F0F, -1, -1, 2, 'h0F0F, "R2");
    cpu_op(1, 'h0E, 'h1357, 0, 0, 1, -1, 4, -1, "R11");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end
endmodule